// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets an on-chip requester read and write an external asynchronous static RAM of 65,536 words by 16 bits. The requester offers one access at a time over a valid/ready handshake. Each access carries an address, a write flag, write data and a per-byte lane mask. A read returns its data with a one-cycle valid strobe. On the memory side the controller drives the address, an active-low chip select, an output enable, a write strobe and one active-low enable per byte lane. The data bus is split into an outgoing word, an incoming word and a drive-enable, so the pad ring can build the bidirectional pin.

All memory timing is expressed in clock cycles through parameters:
- the access wait before read data is sampled;
- the width of the write pulse;
- the float gap after a read;
- the recovery gap after a write.

The strobes leave the block from registers. Address, lane mask and write data are captured when the request is accepted. All of them stay fixed until the next request is accepted.

Top module: `asyncSramCtl`

## Requirements
- R1: Out of reset and whenever the controller is idle, `reqReady` is 1. In that state chip select, output enable, write strobe and every lane enable are all 1 (inactive), and `sramDqDrive` is 0.
- R2: A write with at least one lane enabled runs in three phases, counted in cycles after the accepting edge. (a) One setup cycle: chip select low, the requested lanes low, output enable high, write strobe high, data driven. (b) `WE_PULSE` cycles with the write strobe low and the same pins held. (c) `RECOVER_CYC` cycles with every strobe high and the bus released. `reqReady` returns only after phase (c).
- R3: During the write pulse the address, the outgoing data and the lane enables do not change. The address also keeps its value in the cycle after the write strobe was low, so the strobe rises no later than any address change.
- R4: Lane i of `reqLaneEn` (1 = enabled) drives `sramLaneN[i]` low (bit 0 = data bits 7:0, bit 1 = bits 15:8). A write changes only the enabled bytes of the addressed word.
- R5: A read with at least one lane enabled holds chip select and output enable low, with the write strobe high and the bus released, for `READ_WAIT` cycles. It samples `sramDqIn` at the edge that ends this window, and raises `rspValid` for exactly the following cycle.
- R6: In returned read data, bytes of lanes that were not enabled are zero, whatever the memory bus carries on them.
- R7: After a read the controller spends `FLOAT_CYC` cycles with all strobes high and the bus released before `reqReady` returns.
- R8: `sramDqDrive` is never 1 while output enable is low. Output enable never falls in the cycle right after a cycle in which the bus was driven.
- R9: A request with both lanes disabled is accepted without any memory strobe. A disabled write changes nothing. A disabled read returns `rspValid` in the next cycle with data zero, and the controller stays ready.
- R10: `reqValid` has no effect while `reqReady` is 0. Such a request produces neither strobe activity nor a later memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqLaneEn | input | DATA_W/LANE_W | Byte lanes to access, 1 = enabled |
| rspValid | output | 1 | One-cycle read-data strobe |
| rspData | output | DATA_W | Read data, disabled lanes zero |
| sramAddr | output | ADDR_W | Memory address |
| sramCeN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write strobe, active low |
| sramLaneN | output | DATA_W/LANE_W | Per-lane byte enable, active low |
| sramDqOut | output | DATA_W | Data toward the memory |
| sramDqIn | input | DATA_W | Data from the memory |
| sramDqDrive | output | 1 | 1 = pad drives `sramDqOut` onto the bus |

## Verification
The hardest situation to reach from the ports is a request held valid while the controller is busy. That request must be ignored and must leave no trace. The bench raises `reqValid` with a write to a live address during a read and drops it exactly one cycle before the controller becomes ready again. A later read of that address must show the old contents. The bench also chains writes and reads with mixed lane masks so that the turnaround gaps in both directions are crossed. It drives a filler pattern on bus lanes the memory model is not driving, so any unmasked byte shows up in the returned data.

// File: rtl/sramCtlPkg.sv
package sramCtlPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_FLOAT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctlState_t;

  // Registered memory-side strobes; laneGate opens the held lane mask.
  typedef struct packed {
    logic chipSelN;
    logic outEnN;
    logic wrEnN;
    logic laneGate;
    logic busDrive;
  } pinStrobes_t;

  // One-cycle commands from control to datapath.
  typedef struct packed {
    logic loadReq;
    logic captureRd;
    logic zeroRd;
  } dpCtl_t;

endpackage

// File: rtl/sramCtlFsm.sv
module sramCtlFsm
  import sramCtlPkg::*;
#(
  parameter int LANES       = 2,
  parameter int READ_WAIT   = 2,
  parameter int WE_PULSE    = 1,
  parameter int FLOAT_CYC   = 1,
  parameter int RECOVER_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [LANES-1:0]  reqLaneEn,
  output logic              reqReady,
  output pinStrobes_t       strobes,
  output dpCtl_t            dpCtl
);

  localparam int RW   = (READ_WAIT   < 1) ? 1 : READ_WAIT;
  localparam int WP   = (WE_PULSE    < 1) ? 1 : WE_PULSE;
  localparam int FL   = (FLOAT_CYC   < 1) ? 1 : FLOAT_CYC;
  localparam int RC   = (RECOVER_CYC < 1) ? 1 : RECOVER_CYC;
  localparam int M1   = (RW > WP) ? RW : WP;
  localparam int M2   = (FL > RC) ? FL : RC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;

  function automatic pinStrobes_t strobeOf(ctlState_t s);
    pinStrobes_t p;
    p = '{chipSelN: 1'b1, outEnN: 1'b1, wrEnN: 1'b1, laneGate: 1'b0, busDrive: 1'b0};
    case (s)
      ST_RD_ACCESS: begin
        p.chipSelN = 1'b0;
        p.outEnN   = 1'b0;
        p.laneGate = 1'b1;
      end
      ST_WR_SETUP: begin
        p.chipSelN = 1'b0;
        p.laneGate = 1'b1;
        p.busDrive = 1'b1;
      end
      ST_WR_PULSE: begin
        p.chipSelN = 1'b0;
        p.wrEnN    = 1'b0;
        p.laneGate = 1'b1;
        p.busDrive = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    dpCtl     = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          dpCtl.loadReq = 1'b1;
          if (reqLaneEn == '0) begin
            dpCtl.zeroRd = !reqWrite;
          end else if (reqWrite) begin
            nextState = ST_WR_SETUP;
          end else begin
            nextState = ST_RD_ACCESS;
            nextCnt   = CNT_W'(RW - 1);
          end
        end
      end
      ST_RD_ACCESS: begin
        if (cnt == '0) begin
          dpCtl.captureRd = 1'b1;
          nextState       = ST_RD_FLOAT;
          nextCnt         = CNT_W'(FL - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_RD_FLOAT: begin
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - 1'b1;
      end
      ST_WR_SETUP: begin
        nextState = ST_WR_PULSE;
        nextCnt   = CNT_W'(WP - 1);
      end
      ST_WR_PULSE: begin
        if (cnt == '0) begin
          nextState = ST_WR_RECOVER;
          nextCnt   = CNT_W'(RC - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_WR_RECOVER: begin
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      strobes <= strobeOf(ST_IDLE);
    end else begin
      state   <= nextState;
      cnt     <= nextCnt;
      strobes <= strobeOf(nextState);
    end
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sramCtlDatapath.sv
module sramCtlDatapath
  import sramCtlPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  pinStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLaneEn,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [LANES-1:0]  sramLaneN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  laneQ;
  logic [DATA_W-1:0] capData;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign capData[g*LANE_W +: LANE_W] =
      laneQ[g] ? sramDqIn[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      laneQ    <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (dpCtl.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        laneQ  <= reqLaneEn;
      end
      if (dpCtl.captureRd)   rspData <= capData;
      else if (dpCtl.zeroRd) rspData <= '0;
      rspValid <= dpCtl.captureRd | dpCtl.zeroRd;
    end
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramLaneN = ~(laneQ & {LANES{strobes.laneGate}});

endmodule

// File: rtl/asyncSramCtl.sv
module asyncSramCtl
  import sramCtlPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int LANE_W      = 8,
  parameter int READ_WAIT   = 2,
  parameter int WE_PULSE    = 1,
  parameter int FLOAT_CYC   = 1,
  parameter int RECOVER_CYC = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W/LANE_W-1:0] reqLaneEn,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData,
  output logic [ADDR_W-1:0]        sramAddr,
  output logic                     sramCeN,
  output logic                     sramOeN,
  output logic                     sramWeN,
  output logic [DATA_W/LANE_W-1:0] sramLaneN,
  output logic [DATA_W-1:0]        sramDqOut,
  input  logic [DATA_W-1:0]        sramDqIn,
  output logic                     sramDqDrive
);

  localparam int LANES = DATA_W / LANE_W;

  pinStrobes_t strobes;
  dpCtl_t      dpCtl;

  sramCtlFsm #(
    .LANES(LANES), .READ_WAIT(READ_WAIT), .WE_PULSE(WE_PULSE),
    .FLOAT_CYC(FLOAT_CYC), .RECOVER_CYC(RECOVER_CYC)
  ) i_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLaneEn(reqLaneEn), .reqReady(reqReady), .strobes(strobes), .dpCtl(dpCtl)
  );

  sramCtlDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) i_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .strobes(strobes),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLaneEn(reqLaneEn),
    .sramDqIn(sramDqIn), .sramAddr(sramAddr), .sramLaneN(sramLaneN),
    .sramDqOut(sramDqOut), .rspData(rspData), .rspValid(rspValid)
  );

  assign sramCeN     = strobes.chipSelN;
  assign sramOeN     = strobes.outEnN;
  assign sramWeN     = strobes.wrEnN;
  assign sramDqDrive = strobes.busDrive;

endmodule

// File: rtl/asyncSramCtlChk.sv
module asyncSramCtlChk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramWeN,
  input logic [LANES-1:0]  sramLaneN,
  input logic [DATA_W-1:0] sramDqOut,
  input logic              sramDqDrive
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCeN && sramOeN && sramWeN && !sramDqDrive && (&sramLaneN)));

  assert_write_pins_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!sramCeN && sramOeN && sramDqDrive));

  assert_pulse_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN && $past(!sramWeN)) |->
      ($stable(sramAddr) && $stable(sramDqOut) && $stable(sramLaneN)));

  assert_addr_after_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |=> $stable(sramAddr));

  assert_read_pins_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> (!sramCeN && sramWeN && !sramDqDrive));

  assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramOeN) |-> !sramDqDrive);

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rstN)
    sramDqDrive |-> sramOeN);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramOeN) |-> !$past(sramDqDrive));

endmodule

bind asyncSramCtl asyncSramCtlChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(DATA_W / LANE_W)
) i_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .sramAddr(sramAddr),
  .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
  .sramLaneN(sramLaneN), .sramDqOut(sramDqOut), .sramDqDrive(sramDqDrive)
);

// File: tb/test_asyncSramCtl.sv
module test_asyncSramCtl;
  localparam int ADDR_W = 16, DATA_W = 16, LANE_W = 8, LANES = 2;
  localparam int READ_WAIT = 2, WE_PULSE = 1, FLOAT_CYC = 1, RECOVER_CYC = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [LANES-1:0]  reqLaneEn = '0;
  logic              reqReady, rspValid;
  logic [DATA_W-1:0] rspData;
  logic [ADDR_W-1:0] sramAddr;
  logic              sramCeN, sramOeN, sramWeN, sramDqDrive;
  logic [LANES-1:0]  sramLaneN;
  logic [DATA_W-1:0] sramDqOut;
  logic [DATA_W-1:0] sramDqIn = 16'hA5A5;

  asyncSramCtl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .READ_WAIT(READ_WAIT),
    .WE_PULSE(WE_PULSE), .FLOAT_CYC(FLOAT_CYC), .RECOVER_CYC(RECOVER_CYC)
  ) i_asyncSramCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqLaneEn(reqLaneEn), .rspValid(rspValid), .rspData(rspData),
    .sramAddr(sramAddr), .sramCeN(sramCeN), .sramOeN(sramOeN),
    .sramWeN(sramWeN), .sramLaneN(sramLaneN), .sramDqOut(sramDqOut),
    .sramDqIn(sramDqIn), .sramDqDrive(sramDqDrive)
  );

  typedef struct {
    logic        ceN, oeN, weN, drive, ready, rv;
    logic [1:0]  laneN;
    logic [15:0] addr, wdata, rdata;
    string       tag, dataTag;
  } cyc_t;

  cyc_t        expQ[$];
  logic [15:0] memArr [int];
  logic [15:0] shadow [int];
  int vectors = 0, miscompares = 0;
  bit checking = 1'b0, done = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic cyc_t idleCyc();
    cyc_t c;
    c.ceN = 1; c.oeN = 1; c.weN = 1; c.drive = 0; c.ready = 1; c.rv = 0;
    c.laneN = 2'b11; c.addr = '0; c.wdata = '0; c.rdata = '0;
    c.tag = "R1"; c.dataTag = "R1";
    return c;
  endfunction

  // Per-cycle comparison and memory model, away from the active edge.
  always @(negedge clk) begin
    if (checking) begin
      cyc_t e;
      logic [15:0] cur, nxt;
      bit memDrv;
      e = (expQ.size() != 0) ? expQ.pop_front() : idleCyc();
      chk(e.tag, "ceN", int'(sramCeN), int'(e.ceN));
      chk(e.tag, "oeN", int'(sramOeN), int'(e.oeN));
      chk(e.tag, "weN", int'(sramWeN), int'(e.weN));
      chk(e.tag, "laneN", int'(sramLaneN), int'(e.laneN));
      chk(e.tag, "drive", int'(sramDqDrive), int'(e.drive));
      chk(e.tag, "ready", int'(reqReady), int'(e.ready));
      chk(e.dataTag, "rspValid", int'(rspValid), int'(e.rv));
      if (!e.ceN) chk(e.tag, "addr", int'(sramAddr), int'(e.addr));
      if (e.drive) chk(e.tag, "wdata", int'(sramDqOut), int'(e.wdata));
      if (e.rv) chk(e.dataTag, "rspData", int'(rspData), int'(e.rdata));
      // memory: write on strobe low
      cur = memArr.exists(int'(sramAddr)) ? memArr[int'(sramAddr)] : 16'h0000;
      if (!sramCeN && !sramWeN) begin
        nxt = cur;
        if (!sramLaneN[0]) nxt[7:0]  = sramDqOut[7:0];
        if (!sramLaneN[1]) nxt[15:8] = sramDqOut[15:8];
        memArr[int'(sramAddr)] = nxt;
        cur = nxt;
      end
      memDrv = 1'b0;
      sramDqIn = 16'hA5A5;
      if (!sramCeN && !sramOeN && sramWeN) begin
        if (!sramLaneN[0]) begin sramDqIn[7:0]  = cur[7:0];  memDrv = 1'b1; end
        if (!sramLaneN[1]) begin sramDqIn[15:8] = cur[15:8]; memDrv = 1'b1; end
      end
      chk("R8", "bus contention", int'(memDrv && sramDqDrive), 0);
    end
  end

  task automatic waitIdle();
    do begin @(posedge clk); #2; end while (expQ.size() != 0);
  endtask

  task automatic issue(bit wr, logic [15:0] a, logic [15:0] d, logic [1:0] lanes);
    cyc_t c;
    logic [15:0] sh, ex;
    waitIdle();
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqLaneEn = lanes;
    @(posedge clk); #2;
    reqValid = 0;
    sh = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (lanes == 2'b00) begin
      if (!wr) begin
        c = idleCyc(); c.rv = 1; c.rdata = 16'h0000; c.tag = "R9"; c.dataTag = "R9";
        expQ.push_back(c);
      end
    end else if (wr) begin
      c = idleCyc(); c.ceN = 0; c.laneN = ~lanes; c.drive = 1; c.ready = 0;
      c.addr = a; c.wdata = d; c.tag = "R2";
      expQ.push_back(c);
      for (int k = 0; k < WE_PULSE; k++) begin
        c.weN = 0; c.tag = "R3"; expQ.push_back(c);
      end
      for (int k = 0; k < RECOVER_CYC; k++) begin
        c = idleCyc(); c.ready = 0; c.tag = "R2"; expQ.push_back(c);
      end
      if (lanes[0]) sh[7:0]  = d[7:0];
      if (lanes[1]) sh[15:8] = d[15:8];
      shadow[int'(a)] = sh;
    end else begin
      c = idleCyc(); c.ceN = 0; c.oeN = 0; c.laneN = ~lanes; c.ready = 0;
      c.addr = a; c.tag = "R5"; c.dataTag = "R5";
      for (int k = 0; k < READ_WAIT; k++) expQ.push_back(c);
      ex = 16'h0000;
      if (lanes[0]) ex[7:0]  = sh[7:0];
      if (lanes[1]) ex[15:8] = sh[15:8];
      for (int k = 0; k < FLOAT_CYC; k++) begin
        c = idleCyc(); c.ready = 0; c.tag = "R7";
        if (k == 0) begin c.rv = 1; c.rdata = ex; c.dataTag = "R6"; end
        expQ.push_back(c);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    checking = 1'b1;
    repeat (3) @(posedge clk);                       // R1 idle after reset
    issue(1, 16'h1234, 16'hBEEF, 2'b11);             // R2 full write
    issue(0, 16'h1234, 16'h0000, 2'b11);             // R5 read back
    issue(1, 16'h1234, 16'h11C3, 2'b01);             // R4 low lane only
    issue(0, 16'h1234, 16'h0000, 2'b11);
    issue(1, 16'h1234, 16'h7E22, 2'b10);             // R4 high lane only
    issue(0, 16'h1234, 16'h0000, 2'b01);             // R6 masked high
    issue(0, 16'h1234, 16'h0000, 2'b10);             // R6 masked low
    issue(1, 16'h1234, 16'hFFFF, 2'b00);             // R9 disabled write
    issue(0, 16'h1234, 16'h0000, 2'b00);             // R9 disabled read
    issue(0, 16'h1234, 16'h0000, 2'b11);             // R9 word unchanged
    issue(1, 16'hFFFF, 16'h5A5A, 2'b11);             // boundary addresses
    issue(1, 16'h0000, 16'hC0DE, 2'b11);
    issue(0, 16'hFFFF, 16'h0000, 2'b11);             // R8 write then read
    issue(1, 16'h0001, 16'h0F0F, 2'b11);             // R8 read then write
    issue(0, 16'h0000, 16'h0000, 2'b11);
    for (int i = 0; i < 8; i++)
      issue(1, 16'(i * 16'h0911), 16'(16'h3C00 + i * 16'h0101), 2'(i % 3 + 1));
    for (int i = 0; i < 8; i++)
      issue(0, 16'(i * 16'h0911), 16'h0000, 2'b11);
    // R10: request held while busy must be ignored
    issue(0, 16'hFFFF, 16'h0000, 2'b11);
    reqValid = 1; reqWrite = 1; reqAddr = 16'hFFFF; reqWdata = 16'h0BAD; reqLaneEn = 2'b11;
    while (expQ.size() > 1) begin @(posedge clk); #2; end
    reqValid = 0;
    issue(0, 16'hFFFF, 16'h0000, 2'b11);             // R10 still 5A5A
    waitIdle();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule